// File: doc/BRIEF.md
# Accumulator Processor Core

A small 16-bit, word-addressed processor core built around an accumulator A, a second general register B and an index register X. It works through each instruction as a chain of single bus steps against one synchronous single-port memory. The memory returns read data on the cycle after a read strobe, and it takes write data on the cycle the write strobe is high. Every defined instruction is two words long: an op-code word and then an operand word. The core keeps the op-code in an op-code register. It keeps an operand address in a temporary address register and an operand value in a temporary data register.

Immediate instructions use the operand word as the value itself. Direct instructions use the operand word as an address and fetch the value from that address with one extra read. Indexed instructions do the same, except that the address is the operand word plus X. Relative jumps add the operand to the instruction pointer. Any word that is not a defined op-code is skipped as a one-word no-operation and reported with a one-cycle pulse.

Top module: `acc_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, all registers and flags clear and the instruction pointer loads 0x0000. In the first cycle after release, the core issues a read of address 0x0000.
- R2: An instruction starts with a read at the instruction pointer. In the following cycle the op-code is latched, the pointer steps by one and the bus is idle. A two-word instruction then reads its operand at the new pointer, latches it in the following idle cycle and steps the pointer again. Every read is followed by one cycle with neither strobe.
- R3: Direct and indexed instructions, other than stores, perform a second read. For direct mode the address is the operand; for indexed mode it is the operand plus X. Immediate instructions perform no second read.
- R4: A store drives one write of the named register to the operand address, in the cycle after the operand is latched. The next instruction fetch follows in the next cycle.
- R5: Subtraction computes the register plus the inverted subtrahend plus one. Addition and subtraction keep the low 16 bits and drop the carry.
- R6: AND immediate combines the operand word itself with the register. AND direct combines the word read from the operand address with the register.
- R7: A jump sets the instruction pointer to (address following the operand word + operand) mod 2^16. The unconditional jump is always taken. Jump-if-zero is taken only while Z is set, and jump-if-negative only while N is set. A jump that is not taken falls through to the next instruction.
- R8: Only add, subtract and AND update the flags. Z is set when the result is zero, and N copies result bit 15. Loads, stores and jumps leave both flags as they were.
- R9: An undefined op-code word takes up one word, changes no register, and raises `illegal_op` for exactly one cycle. That cycle is the one in which the fetch of the next word starts.
- R10: Op-code values (hex). Accumulator: A100 load direct, A1C0 load indexed, B800 load immediate, A300 store direct, 81C0 add immediate, 0300 add direct, 81E8 subtract immediate, 2B00 subtract direct, 25C0 AND immediate, 2300 AND direct. Register B: BB00 load immediate, BB01 load direct, BB02 store direct, BB03 add direct, BB04 subtract immediate, BB05 AND direct. Register X: BE00 load immediate. Jumps: EB00 unconditional, 7400 if zero, 7800 if negative.
- R11: The read strobe and the write strobe are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_rdata | input | 16 | Read data, valid in the cycle after `mem_rd` |
| mem_addr | output | 16 | Word address for the current bus step |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Data to be written when `mem_wr` is high |
| illegal_op | output | 1 | One-cycle pulse after an undefined op-code word |

## Verification
Two of the core's functions share a cycle. The registered undefined-op-code pulse coincides with the read that fetches the following word, so error reporting and instruction fetch meet at one edge. The bench provokes this by placing an undefined word directly ahead of a B-register load, whose result is later stored. The run is judged correct when the pulse is counted exactly once, the store after it writes the value the load and AND imply, and the flag history around it steers the following conditional jumps as expected.

// File: rtl/acc_pkg.sv
// Package acc_pkg
// Shared definitions for the accumulator core: data width, op-code values,
// the decoded-instruction record and the decoder function.
// Assumes every defined instruction is an op-code word plus an operand word.
package acc_pkg;

    localparam int unsigned DW = 16;

    localparam logic [DW-1:0] OP_LDA_DIR = 16'hA100;
    localparam logic [DW-1:0] OP_LDA_IDX = 16'hA1C0;
    localparam logic [DW-1:0] OP_LDA_IMM = 16'hB800;
    localparam logic [DW-1:0] OP_STA_DIR = 16'hA300;
    localparam logic [DW-1:0] OP_ADA_IMM = 16'h81C0;
    localparam logic [DW-1:0] OP_ADA_DIR = 16'h0300;
    localparam logic [DW-1:0] OP_SBA_IMM = 16'h81E8;
    localparam logic [DW-1:0] OP_SBA_DIR = 16'h2B00;
    localparam logic [DW-1:0] OP_ANA_IMM = 16'h25C0;
    localparam logic [DW-1:0] OP_ANA_DIR = 16'h2300;
    localparam logic [DW-1:0] OP_LDB_IMM = 16'hBB00;
    localparam logic [DW-1:0] OP_LDB_DIR = 16'hBB01;
    localparam logic [DW-1:0] OP_STB_DIR = 16'hBB02;
    localparam logic [DW-1:0] OP_ADB_DIR = 16'hBB03;
    localparam logic [DW-1:0] OP_SBB_IMM = 16'hBB04;
    localparam logic [DW-1:0] OP_ANB_DIR = 16'hBB05;
    localparam logic [DW-1:0] OP_LDX_IMM = 16'hBE00;
    localparam logic [DW-1:0] OP_JMP_REL = 16'hEB00;
    localparam logic [DW-1:0] OP_JZ_REL  = 16'h7400;
    localparam logic [DW-1:0] OP_JN_REL  = 16'h7800;

    typedef enum logic [3:0] {K_NOP, K_LD, K_ST, K_ADD, K_SUB, K_AND, K_JMP, K_JZ, K_JN} kind_t;
    typedef enum logic [1:0] {R_A, R_B, R_X} reg_t;
    typedef enum logic [1:0] {M_IMM, M_DIR, M_IDX} mode_t;
    typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_PASS} alu_op_t;

    typedef struct packed {
        logic  valid;
        kind_t kind;
        reg_t  dst;
        mode_t mode;
    } dec_t;

    // Map an op-code word to its kind, target register and addressing mode.
    function automatic dec_t decode(input logic [DW-1:0] op);
        dec_t r;
        r = '{valid: 1'b1, kind: K_NOP, dst: R_A, mode: M_IMM};
        case (op)
            OP_LDA_DIR: begin r.kind = K_LD;  r.mode = M_DIR; end
            OP_LDA_IDX: begin r.kind = K_LD;  r.mode = M_IDX; end
            OP_LDA_IMM: begin r.kind = K_LD;                  end
            OP_STA_DIR: begin r.kind = K_ST;  r.mode = M_DIR; end
            OP_ADA_IMM: begin r.kind = K_ADD;                 end
            OP_ADA_DIR: begin r.kind = K_ADD; r.mode = M_DIR; end
            OP_SBA_IMM: begin r.kind = K_SUB;                 end
            OP_SBA_DIR: begin r.kind = K_SUB; r.mode = M_DIR; end
            OP_ANA_IMM: begin r.kind = K_AND;                 end
            OP_ANA_DIR: begin r.kind = K_AND; r.mode = M_DIR; end
            OP_LDB_IMM: begin r.kind = K_LD;  r.dst = R_B;    end
            OP_LDB_DIR: begin r.kind = K_LD;  r.dst = R_B; r.mode = M_DIR; end
            OP_STB_DIR: begin r.kind = K_ST;  r.dst = R_B; r.mode = M_DIR; end
            OP_ADB_DIR: begin r.kind = K_ADD; r.dst = R_B; r.mode = M_DIR; end
            OP_SBB_IMM: begin r.kind = K_SUB; r.dst = R_B;    end
            OP_ANB_DIR: begin r.kind = K_AND; r.dst = R_B; r.mode = M_DIR; end
            OP_LDX_IMM: begin r.kind = K_LD;  r.dst = R_X;    end
            OP_JMP_REL: begin r.kind = K_JMP;                 end
            OP_JZ_REL:  begin r.kind = K_JZ;                  end
            OP_JN_REL:  begin r.kind = K_JN;                  end
            default:    begin r.valid = 1'b0;                 end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/acc_alu.sv
// Module acc_alu
// Combinational arithmetic/logic unit. It adds, subtracts by adding the
// inverted subtrahend plus one, ANDs, or passes operand b through. The carry
// out is dropped, and zero/negative indications are derived from the result.
// Assumes the caller decides whether the flags are kept.
module acc_alu
    import acc_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  alu_op_t      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         zf,
    output logic         nf
);

    // Select the result for the requested operation.
    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a + ~b + W'(1);
            ALU_AND: y = a & b;
            default: y = b;
        endcase
    end

    // Derive the status indications from the result.
    always_comb begin
        zf = (y == '0);
        nf = y[W-1];
    end

endmodule

// File: rtl/acc_addr_unit.sv
// Module acc_addr_unit
// Forms the bus address. During fetch steps it uses the instruction pointer.
// Otherwise it uses the effective address: the temporary address register,
// plus the index register when indexed mode is selected.
// Assumes the effective address wraps modulo 2^W.
module acc_addr_unit #(
    parameter int unsigned W = 16
) (
    input  logic         use_ip,
    input  logic         indexed,
    input  logic [W-1:0] ip,
    input  logic [W-1:0] tar,
    input  logic [W-1:0] xr,
    output logic [W-1:0] addr
);

    logic [W-1:0] ea;

    // Compute the effective address and choose the bus address.
    always_comb begin
        ea   = tar + (indexed ? xr : '0);
        addr = use_ip ? ip : ea;
    end

endmodule

// File: rtl/acc_core.sv
// Module acc_core
// Accumulator processor core. Each instruction runs as visible micro-steps:
// fetch read, op-code latch with pointer step, operand read, operand latch
// with pointer step, an optional indirection read and latch, then execute.
// Assumes a synchronous memory: data appears the cycle after mem_rd.
// Reset is synchronous and active low.
module acc_core
    import acc_pkg::*;
#(
    parameter int unsigned    W      = DW,
    parameter logic [W-1:0]   RST_IP = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] mem_rdata,
    output logic [W-1:0] mem_addr,
    output logic         mem_rd,
    output logic         mem_wr,
    output logic [W-1:0] mem_wdata,
    output logic         illegal_op
);

    typedef enum logic [2:0] {S_FETCH, S_DECODE, S_OPRD, S_OPLAT, S_MEMRD, S_MEMLAT, S_EXEC} st_t;

    st_t          st;
    logic [W-1:0] ip, ir, tar, tdr, ra, rb, xr;
    logic         zfl, nfl;
    dec_t         d;
    alu_op_t      aop;
    logic [W-1:0] alu_y, alu_a;
    logic         alu_z, alu_n;

    // Decode straight from the bus while latching, else from the op-code register.
    always_comb d = decode(st == S_DECODE ? mem_rdata : ir);

    // Choose the ALU operation and the register operand.
    always_comb begin
        case (d.kind)
            K_ADD:   aop = ALU_ADD;
            K_SUB:   aop = ALU_SUB;
            K_AND:   aop = ALU_AND;
            default: aop = ALU_PASS;
        endcase
        alu_a = (d.dst == R_B) ? rb : ra;
    end

    // Drive the bus strobes and the store data.
    always_comb begin
        mem_rd    = (st == S_FETCH) || (st == S_OPRD) || (st == S_MEMRD);
        mem_wr    = (st == S_EXEC) && (d.kind == K_ST);
        mem_wdata = (d.dst == R_B) ? rb : ra;
    end

    acc_alu #(.W(W)) u_alu (
        .op (aop),
        .a  (alu_a),
        .b  (tdr),
        .y  (alu_y),
        .zf (alu_z),
        .nf (alu_n)
    );

    acc_addr_unit #(.W(W)) u_addr (
        .use_ip  ((st == S_FETCH) || (st == S_OPRD)),
        .indexed (d.mode == M_IDX),
        .ip      (ip),
        .tar     (tar),
        .xr      (xr),
        .addr    (mem_addr)
    );

    // Step the sequencer and update the architectural registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_FETCH; ip <= RST_IP; ir <= '0; tar <= '0; tdr <= '0;
            ra <= '0; rb <= '0; xr <= '0; zfl <= 1'b0; nfl <= 1'b0;
            illegal_op <= 1'b0;
        end else begin
            illegal_op <= 1'b0;
            case (st)
                S_FETCH: st <= S_DECODE;
                S_DECODE: begin
                    ir <= mem_rdata;
                    ip <= ip + W'(1);
                    if (d.valid) begin
                        st <= S_OPRD;
                    end else begin
                        illegal_op <= 1'b1;
                        st         <= S_FETCH;
                    end
                end
                S_OPRD: st <= S_OPLAT;
                S_OPLAT: begin
                    ip <= ip + W'(1);
                    if (d.mode == M_IMM) begin
                        tdr <= mem_rdata;
                        st  <= S_EXEC;
                    end else begin
                        tar <= mem_rdata;
                        st  <= (d.kind == K_ST) ? S_EXEC : S_MEMRD;
                    end
                end
                S_MEMRD: st <= S_MEMLAT;
                S_MEMLAT: begin
                    tdr <= mem_rdata;
                    st  <= S_EXEC;
                end
                S_EXEC: begin
                    st <= S_FETCH;
                    case (d.kind)
                        K_LD: begin
                            case (d.dst)
                                R_A:     ra <= tdr;
                                R_B:     rb <= tdr;
                                default: xr <= tdr;
                            endcase
                        end
                        K_ADD, K_SUB, K_AND: begin
                            if (d.dst == R_B) rb <= alu_y;
                            else              ra <= alu_y;
                            zfl <= alu_z;
                            nfl <= alu_n;
                        end
                        K_JMP: ip <= ip + tdr;
                        K_JZ:  if (zfl) ip <= ip + tdr;
                        K_JN:  if (nfl) ip <= ip + tdr;
                        default: ;
                    endcase
                end
                default: st <= S_FETCH;
            endcase
        end
    end

endmodule

// File: rtl/acc_core_chk.sv
// Module acc_core_chk
// Bus-protocol checker for acc_core, attached through bind. It watches only
// the ports and relates strobes, addresses and the error pulse over time.
module acc_core_chk #(
    parameter int unsigned  W      = 16,
    parameter logic [W-1:0] RST_IP = '0
) (
    input logic         clk,
    input logic         rst_n,
    input logic         mem_rd,
    input logic         mem_wr,
    input logic [W-1:0] mem_addr,
    input logic         illegal_op
);

    // R1
    reset_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (mem_rd && mem_addr == RST_IP));

    // R2
    read_then_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (!mem_rd && !mem_wr));

    // R4
    store_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> (mem_rd && !mem_wr));

    // R9
    illegal_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |=> !illegal_op);

    // R9
    illegal_at_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> (mem_rd && $past(mem_rd, 2)));

    // R11
    no_rdwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

endmodule

bind acc_core acc_core_chk #(.W(W), .RST_IP(RST_IP)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_addr   (mem_addr),
    .illegal_op (illegal_op)
);

// File: tb/acc_core_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: a driver task queues expected memory writes, and a
// monitor pops and compares them as the core stores results.
module acc_core_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic [15:0] mem_addr, mem_wdata;
    logic        mem_rd, mem_wr, illegal_op;

    int unsigned n_chk = 0, n_bad = 0, n_ill = 0;
    bit          done = 1'b0;
    logic [15:0] mem [0:255];

    typedef struct {logic [15:0] a; logic [15:0] v; string req;} exp_t;
    exp_t q[$];
    exp_t e;

    always #5 clk = ~clk;

    acc_core u_acc_core (
        .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .illegal_op(illegal_op)
    );

    // Synchronous memory model.
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] a, input logic [15:0] op, input logic [15:0] opd);
        mem[a] = op;
        mem[a + 8'd1] = opd;
    endtask

    task automatic expect_wr(input logic [15:0] a, input logic [15:0] v, input string req);
        exp_t x;
        x.a = a; x.v = v; x.req = req;
        q.push_back(x);
    endtask

    // Monitor: compare every write against the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && mem_wr) begin
            if (q.size() == 0) begin
                chk("R7 unexpected write", mem_addr, 16'hDEAD);
            end else begin
                e = q.pop_front();
                chk({e.req, " addr"}, mem_addr, e.a);
                chk({e.req, " data"}, mem_wdata, e.v);
            end
        end
        if (rst_n && illegal_op) n_ill++;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        mem[8'h80] = 16'h0005; mem[8'h81] = 16'h0007;
        mem[8'h82] = 16'h1234; mem[8'h83] = 16'hFFFF;
        put(8'h00, 16'hA100, 16'h0080);  // R3 load direct A=5
        put(8'h02, 16'h2B00, 16'h0081);  // R5 5-7
        put(8'h04, 16'hA300, 16'h0090);
        put(8'h06, 16'h7800, 16'h0002);  // R7 JN taken
        put(8'h08, 16'hA300, 16'h0091);  // skipped
        put(8'h0A, 16'hB800, 16'h0001);  // R8 load keeps N
        put(8'h0C, 16'h7800, 16'h0002);  // taken only if N kept
        put(8'h0E, 16'hA300, 16'h0092);  // skipped
        put(8'h10, 16'h81E8, 16'h0001);  // 1-1=0
        put(8'h12, 16'h7400, 16'h0002);  // JZ taken
        put(8'h14, 16'hA300, 16'h0093);  // skipped
        put(8'h16, 16'hA300, 16'h0094);
        mem[8'h18] = 16'hFFFF;           // R9 undefined word
        put(8'h19, 16'hBB00, 16'h00F0);
        put(8'h1B, 16'hBB05, 16'h0082);  // R6 AND direct
        put(8'h1D, 16'hBB02, 16'h0095);
        put(8'h1F, 16'hB800, 16'h0F01);
        put(8'h21, 16'h25C0, 16'h0300);  // R6 AND immediate
        put(8'h23, 16'hA300, 16'h0096);
        put(8'h25, 16'hBE00, 16'h0002);
        put(8'h27, 16'hA1C0, 16'h0080);  // R3 indexed
        put(8'h29, 16'h81C0, 16'hEDCC);  // R5 carry dropped
        put(8'h2B, 16'hA300, 16'h0097);
        put(8'h2D, 16'h7400, 16'h0002);
        put(8'h2F, 16'hA300, 16'h0098);  // skipped
        put(8'h31, 16'h0300, 16'h0083);
        put(8'h33, 16'hBB03, 16'h0080);
        put(8'h35, 16'hBB04, 16'h0035);
        put(8'h37, 16'hBB02, 16'h0099);
        put(8'h39, 16'hA300, 16'h009A);
        put(8'h3B, 16'h7400, 16'h0002);
        put(8'h3D, 16'hA300, 16'h009B);  // skipped
        put(8'h3F, 16'hBB01, 16'h0081);
        put(8'h41, 16'hBB02, 16'h009C);
        put(8'h43, 16'h25C0, 16'hFFFF);
        put(8'h45, 16'h7400, 16'h0002);  // not taken
        put(8'h47, 16'hA300, 16'h009D);
        put(8'h49, 16'hEB00, 16'hFFFE);  // R7 jump to self

        expect_wr(16'h0090, 16'hFFFE, "R5 subtract direct wraps");
        expect_wr(16'h0094, 16'h0000, "R8 load kept N / R7 JZ taken");
        expect_wr(16'h0095, 16'h0030, "R6 AND direct after R9 undefined word");
        expect_wr(16'h0096, 16'h0300, "R6 AND immediate");
        expect_wr(16'h0097, 16'h0000, "R3 indexed load, R5 add carry dropped");
        expect_wr(16'h0099, 16'h0000, "R10 B-register add/subtract");
        expect_wr(16'h009A, 16'hFFFF, "R4 store A after add direct");
        expect_wr(16'h009C, 16'h0007, "R3 load B direct");
        expect_wr(16'h009D, 16'hFFFF, "R7 JZ not taken falls through");

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset read strobe", {15'd0, mem_rd}, 16'h0001);
        chk("R1 reset address", mem_addr, 16'h0000);
        chk("R11 reset no write", {15'd0, mem_wr}, 16'h0000);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R2 latch cycle idle", {14'd0, mem_rd, mem_wr}, 16'h0000);
        repeat (1500) @(posedge clk);
        @(negedge clk);
        chk("R9 illegal pulse cycles", 16'(n_ill), 16'h0001);
        chk("R4 all expected writes seen", 16'(q.size()), 16'h0000);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule